// File: doc/BRIEF.md
# Power-of-Two Signed Divide and Remainder Unit

This block divides a W-bit operand by 2^k, or returns the remainder of that division, without a divider. A flooring quotient comes from a right shift (arithmetic for two's-complement operands, logical otherwise). A flooring remainder comes from masking the dividend down to its k low bits. Truncating (round-toward-zero) results are derived from those same two values by a one-bit correction that depends only on the dividend's sign and on whether any of the k low bits are set.

The caller presents the dividend, the exponent, and three control bits together with a valid strobe. One clock later the selected result appears on a registered output with its own valid strobe. The intended use is address arithmetic, fixed-point scaling, and bucket indexing where the divisor is always a power of two and a one-cycle, shift-sized datapath is preferred to an iterative divider.

Top module: `pow2_divmod`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `result` is 0. An accepted request (`in_valid`=1 at a rising edge) sets `out_valid` to 1 for exactly the next cycle, and `result` carries that request's answer in the same cycle.
- R2: The control encodings are as follows. `is_signed`=1 treats `dividend` as two's complement and 0 treats it as unsigned. `want_rem`=1 selects the remainder and 0 selects the quotient. `trunc_mode`=1 rounds toward zero and 0 rounds toward minus infinity (flooring). The divisor is 2^`shamt`.
- R3: For a signed flooring quotient, the result is the dividend shifted right arithmetically by `shamt`, with the sign bit filling the vacated upper bits.
- R4: For an unsigned quotient, the result is the dividend shifted right logically by `shamt`, and the same value is produced whether `trunc_mode` is 0 or 1.
- R5: For a signed truncating quotient, the result is the flooring quotient plus one when the dividend is negative and at least one of its low `shamt` bits is set. Otherwise it equals the flooring quotient. The addition wraps modulo 2^W.
- R6: For a flooring remainder, signed or unsigned, the result is the dividend's low `shamt` bits with every upper bit 0. The unsigned truncating remainder is the same value.
- R7: For a signed truncating remainder, the low `shamt` bits equal those of the dividend. Every upper bit equals the dividend's sign bit ANDed with "low bits nonzero", so a zero remainder is all zeros.
- R8: When `shamt` is 0, the quotient equals the dividend and the remainder is 0 in every mode.
- R9: When `in_valid` is 0 at a rising edge, `result` keeps its previous value and `out_valid` is 0 in the following cycle, whatever the other inputs are.
- R10: Legal exponents are 0 to W-2 for signed operands and 0 to W-1 for unsigned operands. Within that range, results match integer division and modulo with the selected rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| dividend | input | W | Operand to divide |
| shamt | input | KW = $clog2(W) | Exponent k; divisor is 2^k |
| is_signed | input | 1 | 1: two's-complement operand |
| want_rem | input | 1 | 1: remainder, 0: quotient |
| trunc_mode | input | 1 | 1: round toward zero, 0: flooring |
| out_valid | output | 1 | Result strobe, one cycle after request |
| result | output | W | Registered quotient or remainder |

## Verification
A fault in the shared low-bit mask or in the nonzero flag would corrupt both the remainder and the truncating quotient. It would show at `result` one cycle after the offending request, and only for negative dividends with nonzero low bits or for particular exponents. For that reason the bench sweeps every 8-bit dividend against every legal exponent in all eight mode combinations and compares each result with integer division. A wrong output-register enable would show as a changed `result` during idle cycles, so the hold scenario checks the output through several idle cycles while the inputs are changing.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;
  typedef enum logic {
    ROUND_FLOOR = 1'b0,
    ROUND_TRUNC = 1'b1
  } round_e;

  typedef enum logic {
    SEL_QUOT = 1'b0,
    SEL_REM  = 1'b1
  } sel_e;
endpackage

// File: rtl/pow2_lowbits.sv
module pow2_lowbits #(
  parameter int W  = 8,
  parameter int KW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [KW-1:0] k,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  low,
  output logic          nz
);
  // Bit i of the mask is set when i lies below the exponent.
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (i < int'(k));
  end

  assign low = a & mask;
  assign nz  = |low;
endmodule

// File: rtl/pow2_quot.sv
module pow2_quot #(
  parameter int W  = 8,
  parameter int KW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [KW-1:0] k,
  input  logic          sgn,
  input  logic          trunc,
  input  logic          nz,
  output logic [W-1:0]  q
);
  logic [W-1:0] q_floor;
  logic         bump;

  always_comb begin
    if (sgn) q_floor = $unsigned($signed(a) >>> k);
    else     q_floor = a >> k;
  end

  // A negative signed quotient that lost nonzero low bits is
  // rounded back up toward zero.
  assign bump = sgn & trunc & a[W-1] & nz;
  assign q    = q_floor + {{(W-1){1'b0}}, bump};
endmodule

// File: rtl/pow2_rem.sv
module pow2_rem #(
  parameter int W = 8
) (
  input  logic [W-1:0] low,
  input  logic [W-1:0] mask,
  input  logic         a_msb,
  input  logic         sgn,
  input  logic         trunc,
  input  logic         nz,
  output logic [W-1:0] r
);
  logic ext;

  // A truncating remainder takes the dividend's sign, except when it is zero.
  assign ext = sgn & trunc & a_msb & nz;
  assign r   = low | ({W{ext}} & ~mask);
endmodule

// File: rtl/pow2_divmod.sv
module pow2_divmod #(
  parameter int W  = 8,
  parameter int KW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  dividend,
  input  logic [KW-1:0] shamt,
  input  logic          is_signed,
  input  logic          want_rem,
  input  logic          trunc_mode,
  output logic          out_valid,
  output logic [W-1:0]  result
);
  import pow2div_pkg::*;

  sel_e         sel;
  round_e       rnd;
  logic [W-1:0] mask, low, quot, rem, nxt;
  logic         nz;

  assign sel = sel_e'(want_rem);
  assign rnd = round_e'(trunc_mode);

  pow2_lowbits #(.W(W), .KW(KW)) u_low (
    .a(dividend), .k(shamt), .mask(mask), .low(low), .nz(nz)
  );

  pow2_quot #(.W(W), .KW(KW)) u_quot (
    .a(dividend), .k(shamt), .sgn(is_signed),
    .trunc(rnd == ROUND_TRUNC), .nz(nz), .q(quot)
  );

  pow2_rem #(.W(W)) u_rem (
    .low(low), .mask(mask), .a_msb(dividend[W-1]), .sgn(is_signed),
    .trunc(rnd == ROUND_TRUNC), .nz(nz), .r(rem)
  );

  assign nxt = (sel == SEL_REM) ? rem : quot;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R1: an accepted request produces a result strobe one cycle later
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9: idle cycles leave the result untouched
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R6: a flooring remainder has no bits at or above the exponent
  assert_floor_rem_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && want_rem && !trunc_mode) |=>
      ((result & ({W{1'b1}} << $past(shamt))) == '0));

  // R7: a non-negative signed dividend never yields a negative truncating remainder
  assert_trunc_rem_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && want_rem && trunc_mode && is_signed && !dividend[W-1]) |=>
      !result[W-1]);

  // R8: a zero exponent passes the dividend through as the quotient
  assert_k0_quot_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !want_rem && shamt == '0) |=> (result == $past(dividend)));
endmodule

// File: tb/pow2_divmod_tb.sv
`timescale 1ns/1ps
module pow2_divmod_tb;
  localparam int W  = 8;
  localparam int KW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  dividend = '0;
  logic [KW-1:0] shamt = '0;
  logic          is_signed = 1'b0;
  logic          want_rem = 1'b0;
  logic          trunc_mode = 1'b0;
  logic          out_valid;
  logic [W-1:0]  result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pow2_divmod #(.W(W), .KW(KW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend),
    .shamt(shamt), .is_signed(is_signed), .want_rem(want_rem),
    .trunc_mode(trunc_mode), .out_valid(out_valid), .result(result)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_val(input logic [W-1:0] d, input int k,
                                           input bit sg, input bit rm, input bit tr);
    int a, dv, q, r;
    dv = 1 << k;
    a  = sg ? int'($signed(d)) : int'(d);
    q  = a / dv;
    r  = a % dv;
    if (!tr && r != 0 && r < 0) begin
      q = q - 1;
      r = r + dv;
    end
    return rm ? r[W-1:0] : q[W-1:0];
  endfunction

  task automatic issue(input logic [W-1:0] d, input int k, input bit sg,
                       input bit rm, input bit tr, input string req);
    @(negedge clk);
    dividend = d; shamt = KW'(k); is_signed = sg; want_rem = rm; trunc_mode = tr;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {{(W-1){1'b0}}, out_valid}, 8'd1);
    check(req, result, ref_val(d, k, sg, rm, tr));
  endtask

  task automatic sweep(input bit sg, input bit rm, input bit tr, input string req);
    int kmax;
    kmax = sg ? W - 2 : W - 1;
    for (int k = 0; k <= kmax; k++)
      for (int d = 0; d < (1 << W); d++)
        issue(W'(d), k, sg, rm, tr, req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R1 reset result", result, '0);
    rst = 1'b0;
  endtask

  task automatic t_signed_floor_quot();  sweep(1, 0, 0, "R3 R10 signed floor quotient");  endtask
  task automatic t_unsigned_quot();
    sweep(0, 0, 0, "R4 unsigned floor quotient");
    sweep(0, 0, 1, "R4 unsigned trunc quotient");
  endtask
  task automatic t_signed_trunc_quot();  sweep(1, 0, 1, "R5 R10 signed trunc quotient");  endtask
  task automatic t_floor_rem();
    sweep(1, 1, 0, "R6 signed floor remainder");
    sweep(0, 1, 0, "R6 unsigned floor remainder");
    sweep(0, 1, 1, "R6 unsigned trunc remainder");
  endtask
  task automatic t_trunc_rem();          sweep(1, 1, 1, "R7 signed trunc remainder");     endtask

  task automatic t_corners();
    // R5: -1/2 -> 0, -128/64 -> -2, -127/64 -> -1
    issue(8'hFF, 1, 1, 0, 1, "R5 minus one half");
    check("R5 literal", result, 8'h00);
    issue(8'h80, 6, 1, 0, 1, "R5 most negative");
    check("R5 literal", result, 8'hFE);
    issue(8'h81, 6, 1, 0, 1, "R5 most negative plus one");
    check("R5 literal", result, 8'hFF);
    // R7: -5 rem 4 trunc = -1 (8'hFF), floor = 3
    issue(8'hFB, 2, 1, 1, 1, "R7 minus five trunc rem");
    check("R7 literal", result, 8'hFF);
    issue(8'hFB, 2, 1, 1, 0, "R6 minus five floor rem");
    check("R6 literal", result, 8'h03);
    // R8: k = 0 in every mode
    for (int m = 0; m < 8; m++) begin
      issue(8'hA5, 0, m[0], m[1], m[2], "R8 zero exponent");
      check("R8 literal", result, m[1] ? 8'h00 : 8'hA5);
    end
    // R2: encodings; 0x90 / 16 signed floor = -7 (F9), unsigned = 9
    issue(8'h90, 4, 1, 0, 0, "R2 signed select");
    check("R2 literal", result, 8'hF9);
    issue(8'h90, 4, 0, 0, 0, "R2 unsigned select");
    check("R2 literal", result, 8'h09);
  endtask

  task automatic t_hold();
    issue(8'h37, 2, 0, 0, 0, "R9 setup");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dividend = W'(i * 61); shamt = KW'(i); want_rem = i[0];
      check("R9 idle valid", {{(W-1){1'b0}}, out_valid}, '0);
      check("R9 held result", result, 8'h0D);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_signed_floor_quot();
    t_unsigned_quot();
    t_signed_trunc_quot();
    t_floor_rem();
    t_trunc_rem();
    t_corners();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule